// File: doc/BRIEF.md
# Power-driver short-circuit mismatch detector

This block watches a group of PWM-driven power output pins and flags short circuits. For each pin it compares the level the driver is commanded to produce with the level sensed back from the pad. Any disagreement counts as a mismatch. A higher level of logic is expected to condition the pad level, so that a commanded high pulled well below the driver supply reads as low, and a commanded low pulled well above driver ground reads as high.

The comparison is not continuous. Each channel samples it once per PWM period, on a strobe placed a fixed quarter bus cycle after that channel's period start, pushed later by the channel's microshift setting. By then the pad has settled. Timing runs from a clock at four times the bus rate, so one clock tick is a quarter bus cycle. The strobe lands `1 + shift` ticks after the tick that carries the period-start pulse, which is 1 to 4 ticks. A shift of 3 therefore lands on the start of the next bus cycle.

A captured mismatch sets a sticky bit in a status word that has one bit per pin. Software polls the word, which is always visible on `flags` and has no read side effects. Software clears bits by writing ones to them.

Top module: `pwr_short_monitor`

## Requirements
- R1: While `rst_n` is low, every bit of `flags` becomes 0 at the next rising clock edge.
- R2: On a channel's strobe tick, bit i of `flags` becomes 1 from the following tick if `cmd_lvl[i]` differs from `pad_lvl[i]`. It stays unchanged if they agree.
- R3: The strobe for channel i falls exactly `1 + s` ticks after a tick with `period_start[i]` high, where `s = ushift[2i+1:2i]` is taken on that start tick. A mismatch on any other tick has no effect on `flags`.
- R4: A set bit stays set on every following tick unless it is cleared by a write.
- R5: A tick with `wr_en` high clears every `flags` bit whose `wr_data` bit is 1 and leaves the bits whose `wr_data` bit is 0 unchanged.
- R6: If a capture and a write-one clear hit the same bit on the same tick, the bit ends up set.
- R7: A channel that never receives `period_start` never sets its bit, whatever its levels do.
- R8: A new `period_start` arriving while a strobe is still pending restarts that channel's countdown with the shift seen on the new start tick. The old strobe point is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock, four ticks per bus cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_lvl | input | CH | Commanded output level per pin |
| pad_lvl | input | CH | Sensed pad level per pin |
| period_start | input | CH | One-tick pulse marking each channel's PWM period start |
| ushift | input | CH*SHW | Per-channel microshift, field i at bits [SHW*i +: SHW] |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | CH | Write data, a 1 clears the matching flag |
| flags | output | CH | Sticky mismatch status, read at any time |

## Verification
The bench places a mismatch only on the expected strobe tick, and then everywhere except that tick, for every shift value. A strobe that is off by one tick therefore shows up either as a missed short or as a false one. It lines up a capture with a write-one clear on the same bit, where a design that gave priority to the clear would lose the event. It also checks that a zero written to a bit, or a one written to a neighbouring bit, leaves a set bit in place. Two further cases cover the countdown. A restart during a pending window must sample only at the new point, where a design that kept the first countdown would sample late. A channel held with mismatching levels but no period start must stay clear.

// File: rtl/pwr_short_monitor.sv
module pwr_short_monitor #(
  parameter int CH  = 8,
  parameter int SHW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH-1:0]     cmd_lvl,
  input  logic [CH-1:0]     pad_lvl,
  input  logic [CH-1:0]     period_start,
  input  logic [CH*SHW-1:0] ushift,
  input  logic              wr_en,
  input  logic [CH-1:0]     wr_data,
  output logic [CH-1:0]     flags
);
  localparam int CW = $clog2((1 << SHW) + 1);

  logic [CW-1:0] cnt [CH];
  logic [CH-1:0] strobe;
  logic [CH-1:0] hit;
  logic [CH-1:0] clr;

  for (genvar i = 0; i < CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt[i] <= '0;
      else if (period_start[i])
        cnt[i] <= CW'(ushift[i*SHW +: SHW]) + CW'(1);
      else if (cnt[i] != '0)
        cnt[i] <= cnt[i] - CW'(1);
    end
    assign strobe[i] = (cnt[i] == CW'(1));
  end

  assign hit = strobe & (cmd_lvl ^ pad_lvl);
  assign clr = wr_en ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)
      flags <= '0;
    else
      flags <= (flags & ~clr) | hit;
  end
endmodule

// File: rtl/pwr_short_monitor_chk.sv
module pwr_short_monitor_chk #(
  parameter int CH  = 8,
  parameter int SHW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CH-1:0]     cmd_lvl,
  input logic [CH-1:0]     pad_lvl,
  input logic [CH-1:0]     period_start,
  input logic [CH*SHW-1:0] ushift,
  input logic              wr_en,
  input logic [CH-1:0]     wr_data,
  input logic [CH-1:0]     flags,
  input logic [CH-1:0]     strobe
);
  logic [CH-1:0] zmask;
  logic [CH-1:0] wmask;
  logic [CH-1:0] diff;

  always_comb
    for (int i = 0; i < CH; i++)
      zmask[i] = (ushift[i*SHW +: SHW] == '0);

  assign wmask = wr_en ? wr_data : '0;
  assign diff  = cmd_lvl ^ pad_lvl;

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> flags == '0);

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags) & ~$past(wmask)) & ~flags) == '0));

  a_r2_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flags & ~$past(flags)) & ~$past(strobe & diff)) == '0));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(strobe & diff & wmask)) & ~flags) == '0));

  a_r3_zero_shift_next: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(period_start & zmask) & ~strobe) == '0));

  a_r5_clear_effect: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(wmask) & ~$past(strobe & diff)) & flags) == '0));
endmodule

bind pwr_short_monitor pwr_short_monitor_chk #(.CH(CH), .SHW(SHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_lvl(cmd_lvl), .pad_lvl(pad_lvl),
  .period_start(period_start), .ushift(ushift), .wr_en(wr_en),
  .wr_data(wr_data), .flags(flags), .strobe(strobe)
);

// File: tb/tb_pwr_short_monitor.sv
module tb_pwr_short_monitor;
  localparam int CH = 8;
  localparam int SHW = 2;
  localparam logic [7:0] CMD = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CH-1:0] cmd_lvl = CMD, pad_lvl = CMD, period_start = '0, wr_data = '0;
  logic [CH*SHW-1:0] ushift = '0;
  logic wr_en = 1'b0;
  logic [CH-1:0] flags;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pwr_short_monitor #(.CH(CH), .SHW(SHW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_lvl(cmd_lvl), .pad_lvl(pad_lvl),
    .period_start(period_start), .ushift(ushift), .wr_en(wr_en),
    .wr_data(wr_data), .flags(flags)
  );

  // {ch[2:0], shift[1:0], mismatch on strobe, mismatch elsewhere, expected}
  localparam logic [7:0] VEC [10] = '{
    {3'd0, 2'd0, 1'b1, 1'b0, 1'b1},
    {3'd1, 2'd1, 1'b1, 1'b0, 1'b1},
    {3'd2, 2'd2, 1'b1, 1'b0, 1'b1},
    {3'd3, 2'd3, 1'b1, 1'b0, 1'b1},
    {3'd4, 2'd0, 1'b0, 1'b1, 1'b0},
    {3'd5, 2'd1, 1'b0, 1'b1, 1'b0},
    {3'd6, 2'd2, 1'b0, 1'b1, 1'b0},
    {3'd7, 2'd3, 1'b0, 1'b1, 1'b0},
    {3'd7, 2'd0, 1'b0, 1'b0, 1'b0},
    {3'd0, 2'd3, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [CH-1:0] act, input logic [CH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); wr_en = 1'b1; wr_data = '1;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic run(input int ch, input int sh, input bit on, input bit off);
    @(negedge clk);
    ushift[ch*SHW +: SHW] = SHW'(sh);
    period_start[ch] = 1'b1;
    pad_lvl = CMD ^ (CH'(off) << ch);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      period_start = '0;
      pad_lvl = CMD ^ (CH'((k == sh + 1) ? on : off) << ch);
    end
    @(negedge clk);
    pad_lvl = CMD;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", flags, '0);
    rst_n = 1'b1;

    for (int v = 0; v < 10; v++) begin
      clear_all();
      run(int'(VEC[v][7:5]), int'(VEC[v][4:3]), VEC[v][2], VEC[v][1]);
      chk("R2 R3 strobe vector", flags, CH'(VEC[v][0]) << VEC[v][7:5]);
    end

    clear_all();
    run(1, 0, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    chk("R4 sticky", flags, 8'h02);

    wr_en = 1'b1; wr_data = 8'hFD;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    chk("R5 zero write keeps", flags, 8'h02);
    wr_en = 1'b1; wr_data = 8'h02;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    chk("R5 one write clears", flags, 8'h00);

    run(2, 0, 1'b1, 1'b0);
    chk("R6 preset", flags, 8'h04);
    ushift[2*SHW +: SHW] = '0;
    period_start[2] = 1'b1;
    @(negedge clk);
    period_start = '0;
    pad_lvl = CMD ^ 8'h04;
    wr_en = 1'b1; wr_data = 8'h04;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; pad_lvl = CMD;
    @(negedge clk);
    chk("R6 set wins", flags, 8'h04);

    clear_all();
    pad_lvl = ~CMD;
    repeat (40) @(negedge clk);
    pad_lvl = CMD;
    @(negedge clk);
    chk("R7 no period start", flags, 8'h00);

    ushift[4*SHW +: SHW] = 2'd3;
    period_start[4] = 1'b1;
    @(negedge clk);
    ushift[4*SHW +: SHW] = 2'd0;
    @(negedge clk);
    period_start = '0;
    @(negedge clk);
    @(negedge clk);
    pad_lvl = CMD ^ 8'h10;
    @(negedge clk);
    pad_lvl = CMD;
    repeat (3) @(negedge clk);
    chk("R8 old point dropped", flags, 8'h00);

    ushift[5*SHW +: SHW] = 2'd3;
    period_start[5] = 1'b1;
    @(negedge clk);
    ushift[5*SHW +: SHW] = 2'd0;
    @(negedge clk);
    period_start = '0;
    pad_lvl = CMD ^ 8'h20;
    @(negedge clk);
    pad_lvl = CMD;
    repeat (3) @(negedge clk);
    chk("R8 restart point used", flags, 8'h20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule